// File: doc/BRIEF.md
# Clock Selector Register Bank

This block holds the source-select codes for a group of clock multiplexers. Software writes a new code into a pending copy of the selector. The code reaches the select output, which drives a downstream glitch-free multiplexer, only when software writes a one to that selector's own commit bit. The block models the select-code registers only. The clock switching itself is outside it.

Each 32-bit configuration word packs four 4-bit selector fields. A word can be written three ways: as a whole, through a set alias that ORs ones into the fields, or through a clear alias that clears the written ones. A field can therefore be replaced without touching its neighbours. Software clears the field through the clear alias, sets the new code through the set alias, and then writes the commit bit. Commit bits are laid out 32 selectors per update word, across consecutive update words. Several selectors written in one update write switch together.

Top module: `clksel_bank`

## Requirements
- R1: A write to `0x00+w` (for w below `NUM_WORDS`) loads the pending codes of selectors 4w..4w+3 from bits [3:0], [11:8], [19:16] and [27:24]. Reading `0x00+w` returns the pending codes in those positions. All other bit positions read as zero.
- R2: A write to the set alias `0x20+w` ORs the written ones into the pending fields of word w and leaves all other pending bits unchanged.
- R3: A write to the clear alias `0x40+w` clears each pending field bit written as one and leaves all other pending bits unchanged.
- R4: A change to a pending code that is not followed by an update write leaves `sel_active` unchanged.
- R5: Writing a one to bit b of update word `0x80+u` copies the pending code of selector 32u+b into `sel_active[4s+3:4s]`, where s = 32u+b. The new value is visible after the clock edge that takes the write.
- R6: One update write with several ones commits all of those selectors on the same edge. Selectors whose bits are zero keep their active code.
- R7: Update words are strobes and always read as zero.
- R8: Reading `0x60+w` returns the active codes of word w in the R1 field layout.
- R9: Synchronous reset sets every pending and active code to zero.
- R10: Writes to unmapped addresses have no effect, and reads of unmapped addresses return zero. Unmapped addresses are word indexes at or above `NUM_WORDS`, update indexes at or above the update word count, and region codes 5 to 7 in `addr[7:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Word address: region in [7:5], index in [4:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| sel_active | output | NUM_SEL*4 | Committed select codes, selector s at [4s+3:4s] |

## Verification
Writes to the pending copy and the update strobes take effect on the clock edge that samples `wr_en`. The bench drives every write on a falling edge and removes it on the next falling edge. By then one rising edge has passed, so new pending and active values are checked at that falling edge. Read data is combinational from `addr`, so the bench sets the address on a falling edge and samples `rdata` a nanosecond later, well before the next rising edge. Hold checks read `sel_active` after pending-only writes and before any update write. This makes a missing update gate visible in the same window.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int FIELD_W      = 4;
    localparam int FIELDS       = 4;
    localparam int FIELD_STRIDE = 8;
    localparam int UPD_BITS     = 32;
    localparam int IDX_W        = 5;
    localparam int WORD_SEL_W   = FIELDS * FIELD_W;

    typedef logic [FIELDS-1:0][FIELD_W-1:0] fieldset_t;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_SET  = 3'd1,
        RG_CLR  = 3'd2,
        RG_ACT  = 3'd3,
        RG_UPD  = 3'd4,
        RG_NONE = 3'd7
    } region_e;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        case (a[7:5])
            3'd0:    return RG_CFG;
            3'd1:    return RG_SET;
            3'd2:    return RG_CLR;
            3'd3:    return RG_ACT;
            3'd4:    return RG_UPD;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic fieldset_t unpack_word(input logic [DATA_W-1:0] d);
        fieldset_t f;
        for (int j = 0; j < FIELDS; j++)
            f[j] = d[j*FIELD_STRIDE +: FIELD_W];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input fieldset_t f);
        logic [DATA_W-1:0] d;
        d = '0;
        for (int j = 0; j < FIELDS; j++)
            d[j*FIELD_STRIDE +: FIELD_W] = f[j];
        return d;
    endfunction

endpackage

// File: rtl/clksel_decode.sv
module clksel_decode
    import clksel_pkg::*;
#(
    parameter int NUM_WORDS = 10,
    parameter int NUM_SEL   = 40,
    parameter int NUM_UPD   = 2
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_WORDS-1:0] load_we,
    output logic [NUM_WORDS-1:0] set_we,
    output logic [NUM_WORDS-1:0] clr_we,
    output logic [NUM_SEL-1:0]   commit
);

    region_e          region;
    logic [IDX_W-1:0] idx;

    assign region = region_of(addr);
    assign idx    = addr[IDX_W-1:0];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit        = wr_en && (idx == IDX_W'(w));
        assign load_we[w] = hit && (region == RG_CFG);
        assign set_we[w]  = hit && (region == RG_SET);
        assign clr_we[w]  = hit && (region == RG_CLR);
    end

    for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
        localparam int U = s / UPD_BITS;
        localparam int B = s % UPD_BITS;
        assign commit[s] = wr_en && (region == RG_UPD) &&
                           (idx == IDX_W'(U)) && wdata[B];
    end

endmodule

// File: rtl/clksel_shadow.sv
module clksel_shadow
    import clksel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_we,
    input  logic      set_we,
    input  logic      clr_we,
    input  fieldset_t wfields,
    output fieldset_t pending
);

    fieldset_t nxt;

    always_comb begin
        nxt = pending;
        if (load_we)
            nxt = wfields;
        else if (set_we)
            nxt = pending | wfields;
        else if (clr_we)
            nxt = pending & ~wfields;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending <= '0;
        else
            pending <= nxt;
    end

endmodule

// File: rtl/clksel_commit.sv
module clksel_commit
    import clksel_pkg::*;
#(
    parameter int NUM_SEL = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SEL-1:0]         commit,
    input  logic [NUM_SEL*FIELD_W-1:0] pending_flat,
    output logic [NUM_SEL*FIELD_W-1:0] active_flat
);

    for (genvar s = 0; s < NUM_SEL; s++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                active_flat[s*FIELD_W +: FIELD_W] <= '0;
            else if (commit[s])
                active_flat[s*FIELD_W +: FIELD_W] <= pending_flat[s*FIELD_W +: FIELD_W];
        end
    end

endmodule

// File: rtl/clksel_bank.sv
module clksel_bank
    import clksel_pkg::*;
#(
    parameter int NUM_WORDS = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [7:0]                         addr,
    input  logic [31:0]                        wdata,
    output logic [31:0]                        rdata,
    output logic [NUM_WORDS*FIELDS*FIELD_W-1:0] sel_active
);

    localparam int NUM_SEL = NUM_WORDS * FIELDS;
    localparam int NUM_UPD = (NUM_SEL + UPD_BITS - 1) / UPD_BITS;

    logic [NUM_WORDS-1:0]      load_we, set_we, clr_we;
    logic [NUM_SEL-1:0]        commit;
    logic [NUM_SEL*FIELD_W-1:0] pending_flat;
    fieldset_t                 wfields;
    region_e                   rd_region;

    assign wfields   = unpack_word(wdata);
    assign rd_region = region_of(addr);

    clksel_decode #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_SEL   (NUM_SEL),
        .NUM_UPD   (NUM_UPD)
    ) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .load_we (load_we),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .commit  (commit)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_shadow
        fieldset_t pend_w;
        clksel_shadow u_shadow (
            .clk     (clk),
            .rst     (rst),
            .load_we (load_we[w]),
            .set_we  (set_we[w]),
            .clr_we  (clr_we[w]),
            .wfields (wfields),
            .pending (pend_w)
        );
        assign pending_flat[w*WORD_SEL_W +: WORD_SEL_W] = pend_w;
    end

    clksel_commit #(
        .NUM_SEL (NUM_SEL)
    ) u_commit (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .pending_flat (pending_flat),
        .active_flat  (sel_active)
    );

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr[IDX_W-1:0] == IDX_W'(w)) begin
                if (rd_region == RG_CFG)
                    rdata = pack_word(pending_flat[w*WORD_SEL_W +: WORD_SEL_W]);
                else if (rd_region == RG_ACT)
                    rdata = pack_word(sel_active[w*WORD_SEL_W +: WORD_SEL_W]);
            end
        end
    end

endmodule

// File: rtl/clksel_bank_chk.sv
module clksel_bank_chk #(
    parameter int NUM_SEL = 40
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [7:0]             addr,
    input logic [1:0]             wd_lo,
    input logic [31:0]            rdata,
    input logic [NUM_SEL*4-1:0]   sel_active,
    input logic [7:0]             pend_lo
);

    // R9: active codes are zero right after reset leaves
    p_reset_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sel_active == '0));

    // R4: without an update-region write the active codes hold
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr[7:5] == 3'd4) |=> $stable(sel_active));

    // R5: committing selector 0 copies its pending code
    p_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h80 && wd_lo[0]) |=> (sel_active[3:0] == $past(pend_lo[3:0])));

    // R6: two selectors committed in one write switch together
    p_multi_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h80 && wd_lo == 2'b11) |=> (sel_active[7:0] == $past(pend_lo)));

    // R7: update words read as zero
    p_upd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (addr[7:5] == 3'd4) |-> (rdata == 32'h0));

    // R1: unused bit positions of a pending word read as zero
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (addr[7:5] == 3'd0) |-> ((rdata & 32'hF0F0_F0F0) == 32'h0));

endmodule

bind clksel_bank clksel_bank_chk #(
    .NUM_SEL (NUM_SEL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wd_lo      (wdata[1:0]),
    .rdata      (rdata),
    .sel_active (sel_active),
    .pend_lo    (pending_flat[7:0])
);

// File: tb/clksel_bank_tb.sv
module clksel_bank_tb;

    localparam int NW  = 10;
    localparam int NS  = NW * 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = 8'h00;
    logic [31:0]     wdata = 32'h0;
    logic [31:0]     rdata;
    logic [NS*4-1:0] sel_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_pend [NS];
    logic [3:0] exp_act  [NS];

    always #10 clk = ~clk;

    clksel_bank #(.NUM_WORDS(NW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .sel_active (sel_active)
    );

    // spec model of a write, built from the requirement text
    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int idx = int'(a[4:0]);
        case (a[7:5])
            3'd0, 3'd1, 3'd2: if (idx < NW) begin
                for (int j = 0; j < 4; j++) begin
                    logic [3:0] f = d[j*8 +: 4];
                    if (a[7:5] == 3'd0) exp_pend[idx*4+j] = f;
                    else if (a[7:5] == 3'd1) exp_pend[idx*4+j] |= f;
                    else exp_pend[idx*4+j] &= ~f;
                end
            end
            3'd4: for (int b = 0; b < 32; b++)
                if (d[b] && (idx*32 + b) < NS) exp_act[idx*32+b] = exp_pend[idx*32+b];
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'h0;
        model_write(a, d);
    endtask

    function automatic logic [31:0] word_of(input int w, input bit act);
        logic [31:0] r = '0;
        for (int j = 0; j < 4; j++)
            r[j*8 +: 4] = act ? exp_act[w*4+j] : exp_pend[w*4+j];
        return r;
    endfunction

    task automatic check_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read %02h actual %08h expected %08h", tag, a, rdata, exp);
        end
    endtask

    task automatic check_active(input string tag);
        logic [NS*4-1:0] e;
        for (int s = 0; s < NS; s++) e[s*4 +: 4] = exp_act[s];
        #1;
        checks++;
        if (sel_active !== e) begin
            errors++;
            $display("FAIL %s sel_active actual %h expected %h", tag, sel_active, e);
        end
    endtask

    task automatic t_reset;
        check_active("R9 reset active");
        check_read(8'h03, 32'h0, "R9 reset pending");
        check_read(8'h63, 32'h0, "R9 reset active read");
    endtask

    task automatic t_plain;
        do_write(8'h02, 32'hFFA5_C3B7);
        check_read(8'h02, word_of(2, 0), "R1 plain write");
        check_active("R4 hold after plain write");
    endtask

    task automatic t_set_clear;
        do_write(8'h22, 32'h0008_0100);
        check_read(8'h02, word_of(2, 0), "R2 set alias");
        do_write(8'h42, 32'h0F00_0003);
        check_read(8'h02, word_of(2, 0), "R3 clear alias");
        check_active("R4 hold after alias writes");
    endtask

    task automatic t_commit_single;
        do_write(8'h80, 32'h0000_0100);
        check_active("R5 commit selector 8");
        check_read(8'h62, word_of(2, 1), "R8 active read");
        do_write(8'h02, 32'h0000_0005);
        check_active("R4 pending change no update");
        check_read(8'h62, word_of(2, 1), "R4 active read unchanged");
    endtask

    task automatic t_replace_field;
        do_write(8'h00, 32'h0403_0201);
        do_write(8'h80, 32'h0000_000F);
        check_active("R6 commit four together");
        do_write(8'h40, 32'h0000_0F00);
        do_write(8'h20, 32'h0000_0900);
        do_write(8'h80, 32'h0000_0002);
        check_active("R3 R2 R5 field replace");
        check_read(8'h60, 32'h0403_0901, "R5 neighbours intact");
    endtask

    task automatic t_second_bank;
        do_write(8'h09, 32'h0C0D_0E0F);
        do_write(8'h81, 32'h0000_00A0);
        check_active("R5 second update word");
        check_read(8'h69, word_of(9, 1), "R8 word 9 active");
    endtask

    task automatic t_upd_read;
        check_read(8'h80, 32'h0, "R7 update word 0");
        check_read(8'h81, 32'h0, "R7 update word 1");
    endtask

    task automatic t_unmapped;
        do_write(8'h0A, 32'h0707_0707);
        check_read(8'h0A, 32'h0, "R10 word past end");
        do_write(8'h82, 32'hFFFF_FFFF);
        check_active("R10 update past end");
        do_write(8'hA0, 32'hFFFF_FFFF);
        check_read(8'h00, word_of(0, 0), "R10 region 5 write");
        check_read(8'hA0, 32'h0, "R10 region 5 read");
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            exp_pend[s] = 4'h0;
            exp_act[s]  = 4'h0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_plain;
        t_set_clear;
        t_commit_single;
        t_replace_field;
        t_second_bank;
        t_upd_read;
        t_unmapped;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule